// File: doc/BRIEF.md
# Per-Page Cacheability Attribute Unit

This unit decides, for every access an 8-bit core makes into its 16-bit address space, whether that access may be served by the cache or must go straight to memory. The address space is split into 256-byte pages, and each page has one attribute bit: 1 means cacheable, 0 means uncached. The decision is a purely combinational function of the access address and the stored bits. It therefore adds no cycle to an access, which matters for a core that touches memory on every cycle.

The attribute bits are held in a small bank of byte-wide registers. The core reads and writes this bank through a memory-mapped port. Byte `n` of the bank covers pages `8n` to `8n+7`, and bit `k` of that byte belongs to page `8n+k`. Every page starts out uncached after reset, and software turns on caching once the core is running.

The topmost page holds the core's own control registers. It is always classified as uncached, even when its stored bit is set. Page 0 has no such special case: it is programmed like any other page, so the zero page and stack region can be given any attribute.

Top module: `page_cache_attr`

## Requirements
- R1: While `rst` is high at a rising clock edge, every stored attribute bit is cleared to 0 (uncached) and `cfg_rdata` is cleared to 0.
- R2: A rising edge with `cfg_we` high stores `cfg_wdata` into bank byte `cfg_addr`. Bit `k` of that byte becomes the attribute of page `8*cfg_addr + k`, and no other byte changes.
- R3: `acc_cacheable` equals the stored bit of page `acc_addr[15:8]` in the same cycle, with no register between `acc_addr` and `acc_cacheable`. A value of 1 means cacheable.
- R4: For any `acc_addr` whose page index `acc_addr[15:8]` is 0xFF, `acc_cacheable` is 0, even when the stored bit for that page is 1.
- R5: `cfg_rdata` shows, one cycle after a rising edge, the bank byte that `cfg_addr` selected at that edge. The value is taken before any write at that same edge (read-first).
- R6: A write changes `acc_cacheable` only from the cycle after the write edge onward. During the cycle in which `cfg_we` is high, the lookup still uses the old bit.
- R7: The attribute of page 0 (bank byte 0, bit 0) can be both set and cleared by writes, and the lookup follows it.
- R8: The stored bit of page 0xFF (bank byte 31, bit 7) is kept as written and reads back unchanged through `cfg_rdata`. Only the lookup forces that page to uncached.
- R9: While `cfg_we` is low, the values on `cfg_wdata` and `cfg_addr` do not change any stored bit. This is observed through later reads and lookups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_addr | input | 16 | Address of the core's current access |
| acc_cacheable | output | 1 | 1 when the current access may be cached (combinational) |
| cfg_we | input | 1 | Write strobe for the attribute bank |
| cfg_addr | input | 5 | Bank byte index for both read and write |
| cfg_wdata | input | 8 | Attribute byte to store |
| cfg_rdata | output | 8 | Registered read of the selected attribute byte |

## Verification
Faults in this block show up at one of two places. A bit stored in the wrong position, or a write strobe that leaks, makes `acc_cacheable` wrong in the same cycle that any address in the affected page is presented. The same fault makes `cfg_rdata` wrong one cycle after that byte is selected. The bench keeps a behavioural copy of all 256 bits and compares both outputs every cycle. Every faulty bit is therefore reported at the first lookup or read that touches it. Timing faults are caught by comparing the lookup during the write cycle against the old bit and in the next cycle against the new bit. A missing force on the top page is caught by accesses to page 0xFF while its stored bit is 1.

// File: rtl/page_attr_pkg.sv
package page_attr_pkg;
  typedef enum logic {
    ATTR_UNCACHED = 1'b0,
    ATTR_CACHED   = 1'b1
  } attr_e;

  // pick one byte out of a packed attribute vector
  function automatic logic [7:0] attr_byte(input logic [255:0] v, input int idx);
    return v[idx*8 +: 8];
  endfunction
endpackage

// File: rtl/attr_bank.sv
module attr_bank #(
  parameter int NUM_PAGES = 256,
  parameter int BYTE_W    = 8,
  localparam int NUM_BYTES = NUM_PAGES / BYTE_W,
  localparam int IDX_W     = $clog2(NUM_BYTES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [IDX_W-1:0]     idx,
  input  logic [BYTE_W-1:0]    wdata,
  output logic [BYTE_W-1:0]    rdata,
  output logic [NUM_PAGES-1:0] bits
);
  // one register byte per group of BYTE_W pages; all bits visible at once
  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst)
        bits[g*BYTE_W +: BYTE_W] <= '0;
      else if (we && idx == IDX_W'(g))
        bits[g*BYTE_W +: BYTE_W] <= wdata;
    end
  end

  // read-first registered read port
  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= bits[idx*BYTE_W +: BYTE_W];
  end

  // R2
  write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> bits[$past(idx)*BYTE_W +: BYTE_W] == $past(wdata));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(bits));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (bits == '0 && rdata == '0));
endmodule

// File: rtl/attr_lookup.sv
module attr_lookup #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 8,
  localparam int NUM_PAGES = 1 << PAGE_W
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic [NUM_PAGES-1:0] bits,
  output logic                 cacheable
);
  import page_attr_pkg::*;

  logic [PAGE_W-1:0] page;
  logic              ctrl_page;
  attr_e             attr;

  always_comb begin
    page      = addr[ADDR_W-1 -: PAGE_W];
    ctrl_page = &page;
    attr      = attr_e'(bits[page]);
    cacheable = (attr == ATTR_CACHED) && !ctrl_page;
  end
endmodule

// File: rtl/page_cache_attr.sv
module page_cache_attr #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 8,
  parameter int BYTE_W = 8,
  localparam int NUM_PAGES = 1 << PAGE_W,
  localparam int NUM_BYTES = NUM_PAGES / BYTE_W,
  localparam int IDX_W     = $clog2(NUM_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              acc_cacheable,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_addr,
  input  logic [BYTE_W-1:0] cfg_wdata,
  output logic [BYTE_W-1:0] cfg_rdata
);
  logic [NUM_PAGES-1:0] attr_bits;

  attr_bank #(.NUM_PAGES(NUM_PAGES), .BYTE_W(BYTE_W)) u_bank (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .idx   (cfg_addr),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata),
    .bits  (attr_bits)
  );

  attr_lookup #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_lookup (
    .addr      (acc_addr),
    .bits      (attr_bits),
    .cacheable (acc_cacheable)
  );

  // R3
  lookup_match_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_addr[ADDR_W-1 -: PAGE_W] != '1) |-> acc_cacheable == attr_bits[acc_addr[ADDR_W-1 -: PAGE_W]]);

  // R4
  ctrl_page_uncached_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_addr[ADDR_W-1 -: PAGE_W] == '1) |-> !acc_cacheable);

  // R6
  write_next_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && $stable(acc_addr) && acc_addr[ADDR_W-1 -: PAGE_W] != '1) |=>
      (acc_cacheable == attr_bits[acc_addr[ADDR_W-1 -: PAGE_W]]));
endmodule

// File: tb/tb_page_cache_attr.sv
module tb_page_cache_attr;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] acc_addr = '0;
  logic        acc_cacheable;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  logic [255:0] ref_bits = '0;
  logic [7:0]   exp_rd = '0;

  always #(CLK_P/2) clk = ~clk;

  page_cache_attr dut (
    .clk(clk), .rst(rst), .acc_addr(acc_addr), .acc_cacheable(acc_cacheable),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  // one clock of stimulus, called right after a falling edge
  task automatic step(input logic we, input logic [4:0] a, input logic [7:0] d,
                      input logic [15:0] acc, input string tag);
    logic exp_c;
    vectors++;
    if (cfg_rdata !== exp_rd) begin
      miscompares++;
      $display("FAIL R5 [%s] rdata got %h expected %h", tag, cfg_rdata, exp_rd);
    end
    cfg_we = we; cfg_addr = a; cfg_wdata = d; acc_addr = acc;
    #1;
    exp_c = ref_bits[acc[15:8]] && (acc[15:8] != 8'hFF);
    vectors++;
    if (acc_cacheable !== exp_c) begin
      miscompares++;
      $display("FAIL %s [%s] addr %h cacheable got %b expected %b",
               (acc[15:8] == 8'hFF) ? "R4" : "R3", tag, acc, acc_cacheable, exp_c);
    end
    @(posedge clk);
    exp_rd = ref_bits[a*8 +: 8];
    if (we) ref_bits[a*8 +: 8] = d;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 50000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: every byte reads 0 and every page is uncached after reset
    for (int i = 0; i < 32; i++) step(1'b0, 5'(i), 8'h00, 16'(i * 2048 + 16), "R1");
    step(1'b0, 5'd0, 8'h00, 16'h0000, "R1");

    // R2: byte 3 covers pages 24..31, bit k -> page 24+k
    step(1'b1, 5'd3, 8'b1010_0101, 16'h1000, "R2");
    for (int k = 0; k < 8; k++) step(1'b0, 5'd3, 8'h00, 16'((24 + k) << 8 | 8'h3C), "R2");

    // R6: lookup of page 40 during the write cycle uses old bit, next cycle new
    step(1'b1, 5'd5, 8'hFF, 16'h2877, "R6");
    step(1'b0, 5'd5, 8'h00, 16'h2877, "R6");
    step(1'b1, 5'd5, 8'h00, 16'h2877, "R6");
    step(1'b0, 5'd5, 8'h00, 16'h2877, "R6");

    // R7: page 0 set, then cleared
    step(1'b1, 5'd0, 8'h01, 16'h0012, "R7");
    step(1'b0, 5'd0, 8'h00, 16'h0012, "R7");
    step(1'b1, 5'd0, 8'h00, 16'h00FF, "R7");
    step(1'b0, 5'd0, 8'h00, 16'h00FF, "R7");

    // R4 / R8: byte 31 all ones; page FF forced, page FE follows, readback intact
    step(1'b1, 5'd31, 8'hFF, 16'hFE00, "R8");
    step(1'b0, 5'd31, 8'h00, 16'hFF00, "R4");
    step(1'b0, 5'd31, 8'h00, 16'hFFFF, "R4");
    step(1'b0, 5'd31, 8'h00, 16'hFE80, "R8");
    step(1'b0, 5'd31, 8'h00, 16'hFF42, "R8");

    // R9: data on the port without the strobe changes nothing
    for (int i = 8; i < 16; i++) step(1'b0, 5'(i), 8'hFF, 16'(i << 11), "R9");
    for (int i = 8; i < 16; i++) step(1'b0, 5'(i), 8'h00, 16'(i << 11 | 16'h0100), "R9");

    // mixed traffic
    for (int n = 0; n < 400; n++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0] & r[1], r[6:2], r[14:7], r[31:16], "R3");
    end
    step(1'b0, 5'd0, 8'h00, 16'h0000, "R5");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule